// File: doc/BRIEF.md
# Vector pairwise even/odd transposer

This datapath builds one destination register group from two source groups by exchanging adjacent lanes. In the even form, each even destination lane keeps the first source's own element, and the odd lane beside it takes the second source's element from the even position just below it. In the odd form, each odd lane keeps the second source's own element, and the even lane below it takes the first source's element from the odd position just above it. Both sources, the destination and the mask share one element count. That count is set by the element width, the group multiplier and the register length.

A sequencer issues one operation per cycle with the whole source groups, the old destination contents and the mask. The block applies the usual lane policies: prestart lanes keep their old value, and tail and masked-off lanes either keep their old value or are filled with ones. It rejects operands it cannot legally write. One cycle after issue it returns either a write-enable with the assembled group and a vstart-clear pulse, or an illegal flag. The register file is outside the block.

Top module: `vec_pair_transposer`

## Requirements
- R1: With `odd_form`=0, for every active element i, an even i receives `vs2_grp` element i and an odd i receives `vs1_grp` element i-1. Element i of width EW occupies bits [i*EW +: EW]. `ew_code` 0, 1 and 2 select EW of 8, 16 and 32.
- R2: With `odd_form`=1, for every active element i, an odd i receives `vs1_grp` element i and an even i receives `vs2_grp` element i+1.
- R3: In the odd form, an active even element whose neighbour i+1 is at or past the group lane count (VLMAX) receives zero.
- R4: VLMAX is 2^(`lmul_exp` + `vlen_exp` - (3 + `ew_code`)). Elements at or past VLMAX keep their `old_grp` value in every mode.
- R5: When `vd_idx` equals `vs1_idx` or `vs2_idx`, the operation is illegal: `illegal` pulses and `wr_en` stays low.
- R6: A masked operation (`unmasked`=0) with `vd_idx`=0 is illegal.
- R7: The configuration is illegal when `ew_code` is at or above NUM_EW, when `vlen_exp` exceeds VLEN_EXP_MAX, or when the VLMAX exponent is negative.
- R8: Elements below `vstart` keep their `old_grp` value.
- R9: Elements from `vl` up to VLMAX-1 are tail elements. They become all ones when `tail_ones`=1 and keep `old_grp` otherwise. With `vl`=0, every element in the group is a tail element.
- R10: When `unmasked`=0, element i is active only if `mask[i]`=1. Inactive body elements become all ones when `mask_ones`=1 and keep `old_grp` otherwise. When `unmasked`=1, `mask` has no effect.
- R11: Results appear exactly one clock after the `issue` cycle. For each issue, exactly one of `wr_en` and `illegal` is high for one cycle. `clr_vstart` pulses together with `wr_en`. Without `issue`, both `wr_en` and `illegal` stay low. Back-to-back issues are accepted.
- R12: Synchronous active-high `rst` clears `res_grp`, `wr_en`, `illegal` and `clr_vstart` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Operation valid this cycle |
| odd_form | input | 1 | 0 selects the even form, 1 selects the odd form |
| ew_code | input | 2 | Element width code (0 is 8 bits, 1 is 16, 2 is 32) |
| lmul_exp | input | 2 | Group multiplier exponent, 0 to 3 |
| vlen_exp | input | 3 | Register length exponent in bits |
| vl | input | 6 | Active element count |
| vstart | input | 6 | First element to write |
| tail_ones | input | 1 | Tail policy: 1 fills tail elements with ones |
| mask_ones | input | 1 | Mask policy: 1 fills masked-off elements with ones |
| unmasked | input | 1 | 1 ignores `mask` |
| vd_idx | input | 5 | Destination register index |
| vs1_idx | input | 5 | Second source register index |
| vs2_idx | input | 5 | First source register index |
| mask | input | 32 | Per-element enable, bit i for element i |
| vs2_grp | input | 256 | First source group |
| vs1_grp | input | 256 | Second source group |
| old_grp | input | 256 | Previous destination group |
| res_grp | output | 256 | Assembled destination group |
| wr_en | output | 1 | Destination write enable |
| illegal | output | 1 | Illegal operation flag |
| clr_vstart | output | 1 | Request to clear vstart |

## Verification
The assertions assume that `issue` is low while `rst` is high. They also assume that a legal operation arrives with `vstart` and `vl` no larger than VLMAX, so a nonzero `vstart` always makes element 0 a prestart element. Every legal row of the stimulus table is chosen with `vl` and `vstart` inside the VLMAX its configuration yields. Out-of-range settings are used only on rows that are meant to be rejected as illegal configurations.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_code_e;

    typedef enum logic [1:0] {
        LN_KEEP = 2'd0,
        LN_ONES = 2'd1,
        LN_DATA = 2'd2
    } lane_kind_e;

    // exponent of the lane count of one group
    function automatic int group_pow(input logic [1:0] lmul_exp, input int vlen_exp,
                                     input ew_code_e ew);
        return int'(lmul_exp) + vlen_exp - 3 - int'(ew);
    endfunction

    // policy order: outside group / prestart, then tail, then mask
    function automatic lane_kind_e classify(input logic in_group, input logic prestart,
                                            input logic tail, input logic masked_off,
                                            input logic tail_ones, input logic mask_ones);
        if (!in_group || prestart)
            return LN_KEEP;
        else if (tail)
            return tail_ones ? LN_ONES : LN_KEEP;
        else if (masked_off)
            return mask_ones ? LN_ONES : LN_KEEP;
        else
            return LN_DATA;
    endfunction

endpackage

// File: rtl/vpt_legality.sv
module vpt_legality
    import vpt_pkg::*;
#(
    parameter int IDX_W        = 5,
    parameter int VLEN_EXP_MAX = 5,
    parameter int NUM_EW       = 3,
    parameter int VE_W         = 3,
    parameter int CNT_W        = 6
) (
    input  ew_code_e          ew,
    input  logic [1:0]        lmul_exp,
    input  logic [VE_W-1:0]   vlen_exp,
    input  logic              unmasked,
    input  logic [IDX_W-1:0]  vd_idx,
    input  logic [IDX_W-1:0]  vs1_idx,
    input  logic [IDX_W-1:0]  vs2_idx,
    output logic              bad_op,
    output logic [CNT_W-1:0]  vlmax
);

    int   pw;
    logic cfg_bad;
    logic overlap;
    logic v0_clash;

    always_comb begin
        pw       = group_pow(lmul_exp, int'(vlen_exp), ew);
        cfg_bad  = (int'(ew) >= NUM_EW) || (int'(vlen_exp) > VLEN_EXP_MAX) || (pw < 0);
        overlap  = (vd_idx == vs1_idx) || (vd_idx == vs2_idx);
        v0_clash = !unmasked && (vd_idx == '0);
        bad_op   = cfg_bad || overlap || v0_clash;
        vlmax    = cfg_bad ? '0 : (CNT_W'(1) << pw);
    end

endmodule

// File: rtl/vpt_ew_slice.sv
module vpt_ew_slice
    import vpt_pkg::*;
#(
    parameter int GRP_W = 256,
    parameter int EW    = 8,
    parameter int CNT_W = 6,
    localparam int LANES = GRP_W / EW
) (
    input  logic              odd_form,
    input  logic [CNT_W-1:0]  vl,
    input  logic [CNT_W-1:0]  vstart,
    input  logic [CNT_W-1:0]  vlmax,
    input  logic              tail_ones,
    input  logic              mask_ones,
    input  logic              unmasked,
    input  logic [LANES-1:0]  mask,
    input  logic [GRP_W-1:0]  src_pri,
    input  logic [GRP_W-1:0]  src_sec,
    input  logic [GRP_W-1:0]  old_dst,
    output logic [GRP_W-1:0]  lanes_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EW-1:0] pick;
        lane_kind_e    kind;

        if (i % 2 == 0) begin : g_even
            // even lane: own element, or right neighbour in the odd form
            always_comb begin
                if (!odd_form)
                    pick = src_pri[i*EW +: EW];
                else if (CNT_W'(i + 1) < vlmax)
                    pick = src_pri[(i+1)*EW +: EW];
                else
                    pick = '0;
            end
        end else begin : g_odd
            // odd lane: own element of the second source, or its left neighbour
            always_comb begin
                if (odd_form)
                    pick = src_sec[i*EW +: EW];
                else
                    pick = src_sec[(i-1)*EW +: EW];
            end
        end

        always_comb begin
            kind = classify(CNT_W'(i) < vlmax, CNT_W'(i) < vstart, CNT_W'(i) >= vl,
                            !unmasked && !mask[i], tail_ones, mask_ones);
            case (kind)
                LN_ONES: lanes_out[i*EW +: EW] = '1;
                LN_DATA: lanes_out[i*EW +: EW] = pick;
                default: lanes_out[i*EW +: EW] = old_dst[i*EW +: EW];
            endcase
        end
    end

endmodule

// File: rtl/vec_pair_transposer.sv
module vec_pair_transposer
    import vpt_pkg::*;
#(
    parameter int VLEN_EXP_MAX = 5,
    parameter int NUM_EW       = 3,
    parameter int IDX_W        = 5,
    localparam int GRP_W     = 8 << VLEN_EXP_MAX,
    localparam int MAX_LANES = GRP_W / 8,
    localparam int CNT_W     = $clog2(MAX_LANES + 1),
    localparam int VE_W      = $clog2(VLEN_EXP_MAX + 2)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue,
    input  logic                  odd_form,
    input  logic [1:0]            ew_code,
    input  logic [1:0]            lmul_exp,
    input  logic [VE_W-1:0]       vlen_exp,
    input  logic [CNT_W-1:0]      vl,
    input  logic [CNT_W-1:0]      vstart,
    input  logic                  tail_ones,
    input  logic                  mask_ones,
    input  logic                  unmasked,
    input  logic [IDX_W-1:0]      vd_idx,
    input  logic [IDX_W-1:0]      vs1_idx,
    input  logic [IDX_W-1:0]      vs2_idx,
    input  logic [MAX_LANES-1:0]  mask,
    input  logic [GRP_W-1:0]      vs2_grp,
    input  logic [GRP_W-1:0]      vs1_grp,
    input  logic [GRP_W-1:0]      old_grp,
    output logic [GRP_W-1:0]      res_grp,
    output logic                  wr_en,
    output logic                  illegal,
    output logic                  clr_vstart
);

    ew_code_e         ew;
    logic             bad_op;
    logic [CNT_W-1:0] vlmax;
    logic [GRP_W-1:0] cand [NUM_EW];
    logic [GRP_W-1:0] sel_grp;
    logic [GRP_W-1:0] res_q;
    logic             wr_q;
    logic             ill_q;

    assign ew = ew_code_e'(ew_code);

    vpt_legality #(
        .IDX_W(IDX_W), .VLEN_EXP_MAX(VLEN_EXP_MAX), .NUM_EW(NUM_EW),
        .VE_W(VE_W), .CNT_W(CNT_W)
    ) u_legal (
        .ew(ew), .lmul_exp(lmul_exp), .vlen_exp(vlen_exp), .unmasked(unmasked),
        .vd_idx(vd_idx), .vs1_idx(vs1_idx), .vs2_idx(vs2_idx),
        .bad_op(bad_op), .vlmax(vlmax)
    );

    // one lane network per supported element width
    for (genvar e = 0; e < NUM_EW; e++) begin : g_ew
        localparam int EW    = 8 << e;
        localparam int LANES = GRP_W / EW;
        vpt_ew_slice #(.GRP_W(GRP_W), .EW(EW), .CNT_W(CNT_W)) u_slice (
            .odd_form(odd_form), .vl(vl), .vstart(vstart), .vlmax(vlmax),
            .tail_ones(tail_ones), .mask_ones(mask_ones), .unmasked(unmasked),
            .mask(mask[LANES-1:0]), .src_pri(vs2_grp), .src_sec(vs1_grp),
            .old_dst(old_grp), .lanes_out(cand[e])
        );
    end

    always_comb begin
        sel_grp = old_grp;
        for (int e = 0; e < NUM_EW; e++)
            if (int'(ew) == e) sel_grp = cand[e];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            wr_q  <= 1'b0;
            ill_q <= 1'b0;
        end else begin
            wr_q  <= issue && !bad_op;
            ill_q <= issue && bad_op;
            if (issue && !bad_op)
                res_q <= sel_grp;
        end
    end

    assign res_grp    = res_q;
    assign wr_en      = wr_q;
    assign illegal    = ill_q;
    assign clr_vstart = wr_q;

    a_r5_overlap_illegal: assert property (@(posedge clk) disable iff (rst)
        issue && ((vd_idx == vs1_idx) || (vd_idx == vs2_idx)) |=> illegal && !wr_en);

    a_r6_v0_masked_illegal: assert property (@(posedge clk) disable iff (rst)
        issue && !unmasked && (vd_idx == '0) |=> illegal);

    a_r7_wide_ew_illegal: assert property (@(posedge clk) disable iff (rst)
        issue && (int'(ew_code) >= NUM_EW) |=> illegal);

    a_r11_one_answer: assert property (@(posedge clk) disable iff (rst)
        issue |=> $countones({wr_en, illegal}) == 1);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !wr_en && !illegal);

    a_r8_prestart_keeps: assert property (@(posedge clk) disable iff (rst)
        issue && (vstart != '0) |=> !wr_en || (res_grp[7:0] == $past(old_grp[7:0])));

endmodule

// File: tb/vec_pair_transposer_tb.sv
module vec_pair_transposer_tb;

    localparam int GRP_W = 256;
    localparam int NV    = 15;

    typedef struct packed {
        logic        odd;
        logic [1:0]  ew;
        logic [1:0]  lmul;
        logic [2:0]  vlen;
        logic [5:0]  vl;
        logic [5:0]  vst;
        logic        ta;
        logic        ma;
        logic        vm;
        logic [31:0] mask;
        logic [4:0]  vd;
        logic [4:0]  vs1;
        logic [4:0]  vs2;
        logic [3:0]  tag;
    } vec_t;

    // odd ew lmul vlen vl vst ta ma vm mask vd vs1 vs2 tag
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd3, 3'd5, 6'd32, 6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd1},  // R1
        '{1'b1, 2'd0, 2'd3, 3'd5, 6'd32, 6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd2},  // R2
        '{1'b0, 2'd1, 2'd2, 3'd5, 6'd6,  6'd0, 1'b1, 1'b0, 1'b1, 32'h0,      5'd4,  5'd12, 5'd20, 4'd9},  // R9
        '{1'b1, 2'd2, 2'd3, 3'd5, 6'd7,  6'd1, 1'b0, 1'b1, 1'b0, 32'h5A,     5'd8,  5'd16, 5'd24, 4'd10}, // R10
        '{1'b1, 2'd2, 2'd0, 3'd5, 6'd1,  6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd2,  5'd3,  5'd1,  4'd3},  // R3
        '{1'b0, 2'd0, 2'd3, 3'd5, 6'd32, 6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd16, 5'd16, 5'd24, 4'd5},  // R5
        '{1'b1, 2'd0, 2'd3, 3'd5, 6'd32, 6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd24, 5'd16, 5'd24, 4'd5},  // R5
        '{1'b0, 2'd0, 2'd3, 3'd5, 6'd32, 6'd0, 1'b0, 1'b0, 1'b0, 32'hFFFF,   5'd0,  5'd16, 5'd24, 4'd6},  // R6
        '{1'b0, 2'd3, 2'd3, 3'd5, 6'd4,  6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd7},  // R7
        '{1'b0, 2'd0, 2'd0, 3'd6, 6'd4,  6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd7},  // R7
        '{1'b1, 2'd2, 2'd0, 3'd3, 6'd1,  6'd0, 1'b0, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd7},  // R7
        '{1'b0, 2'd0, 2'd0, 3'd4, 6'd2,  6'd0, 1'b0, 1'b0, 1'b0, 32'h2,      5'd8,  5'd16, 5'd24, 4'd4},  // R4
        '{1'b1, 2'd1, 2'd3, 3'd5, 6'd16, 6'd3, 1'b1, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd8},  // R8
        '{1'b0, 2'd1, 2'd3, 3'd5, 6'd10, 6'd2, 1'b0, 1'b1, 1'b0, 32'hF0F0,   5'd1,  5'd2,  5'd3,  4'd10}, // R10
        '{1'b0, 2'd0, 2'd3, 3'd5, 6'd0,  6'd0, 1'b1, 1'b0, 1'b1, 32'h0,      5'd8,  5'd16, 5'd24, 4'd9}   // R9
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst, issue, odd_form, tail_ones, mask_ones, unmasked;
    logic [1:0]       ew_code, lmul_exp;
    logic [2:0]       vlen_exp;
    logic [5:0]       vl, vstart;
    logic [4:0]       vd_idx, vs1_idx, vs2_idx;
    logic [31:0]      mask;
    logic [GRP_W-1:0] vs2_grp, vs1_grp, old_grp, res_grp;
    logic             wr_en, illegal, clr_vstart;

    vec_pair_transposer u_dut (
        .clk(clk), .rst(rst), .issue(issue), .odd_form(odd_form), .ew_code(ew_code),
        .lmul_exp(lmul_exp), .vlen_exp(vlen_exp), .vl(vl), .vstart(vstart),
        .tail_ones(tail_ones), .mask_ones(mask_ones), .unmasked(unmasked),
        .vd_idx(vd_idx), .vs1_idx(vs1_idx), .vs2_idx(vs2_idx), .mask(mask),
        .vs2_grp(vs2_grp), .vs1_grp(vs1_grp), .old_grp(old_grp),
        .res_grp(res_grp), .wr_en(wr_en), .illegal(illegal), .clr_vstart(clr_vstart)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    function automatic logic [7:0] b2(int k); return 8'(8'h10 + k); endfunction
    function automatic logic [7:0] b1(int k); return 8'(8'h40 + k); endfunction
    function automatic logic [7:0] bo(int k); return 8'(8'hA0 + k); endfunction

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    function automatic int pow_of(vec_t v);
        return int'(v.lmul) + int'(v.vlen) - 3 - int'(v.ew);
    endfunction

    function automatic bit model_illegal(vec_t v);
        return (v.vd == v.vs1) || (v.vd == v.vs2) || (!v.vm && v.vd == 5'd0) ||
               (v.ew == 2'd3) || (v.vlen > 3'd5) || (pow_of(v) < 0);
    endfunction

    function automatic logic [GRP_W-1:0] model_res(vec_t v);
        logic [GRP_W-1:0] r;
        int eb = 1 << v.ew;
        int vlmax = 1 << pow_of(v);
        for (int b = 0; b < 32; b++) begin
            int el = b / eb;
            int bb = b % eb;
            logic [7:0] x;
            if (el >= vlmax || el < int'(v.vst))      x = bo(b);
            else if (el >= int'(v.vl))                x = v.ta ? 8'hFF : bo(b);
            else if (!v.vm && !v.mask[el])            x = v.ma ? 8'hFF : bo(b);
            else if (!v.odd)                          x = (el % 2 == 0) ? b2(el*eb + bb) : b1((el-1)*eb + bb);
            else if (el % 2 == 1)                     x = b1(el*eb + bb);
            else                                      x = (el + 1 < vlmax) ? b2((el+1)*eb + bb) : 8'h00;
            r[b*8 +: 8] = x;
        end
        return r;
    endfunction

    task automatic check(string req, logic [GRP_W-1:0] act, logic [GRP_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        odd_form = v.odd;  ew_code = v.ew;  lmul_exp = v.lmul; vlen_exp = v.vlen;
        vl = v.vl; vstart = v.vst; tail_ones = v.ta; mask_ones = v.ma;
        unmasked = v.vm; mask = v.mask; vd_idx = v.vd; vs1_idx = v.vs1; vs2_idx = v.vs2;
        issue = 1'b1;
    endtask

    task automatic check_result(vec_t v);
        string req = tag_name(int'(v.tag));
        bit bad = model_illegal(v);
        check(req, GRP_W'(illegal), GRP_W'(bad));
        check(req, GRP_W'(wr_en), GRP_W'(!bad));
        check("R11", GRP_W'(clr_vstart), GRP_W'(!bad));
        if (!bad) check(req, res_grp, model_res(v));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; issue = 1'b0; odd_form = 1'b0; ew_code = '0; lmul_exp = '0;
        vlen_exp = 3'd5; vl = '0; vstart = '0; tail_ones = 1'b0; mask_ones = 1'b0;
        unmasked = 1'b1; mask = '0; vd_idx = 5'd8; vs1_idx = 5'd16; vs2_idx = 5'd24;
        for (int k = 0; k < 32; k++) begin
            vs2_grp[k*8 +: 8] = b2(k);
            vs1_grp[k*8 +: 8] = b1(k);
            old_grp[k*8 +: 8] = bo(k);
        end
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", res_grp, '0);
        check("R12", GRP_W'({wr_en, illegal, clr_vstart}), '0);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle gives no pulse
        check("R11", GRP_W'({wr_en, illegal}), '0);

        for (int n = 0; n < NV; n++) begin
            drive(VECS[n]);
            @(negedge clk);
            issue = 1'b0;
            check_result(VECS[n]);
            @(negedge clk);
            // R11: single-cycle pulse
            check("R11", GRP_W'({wr_en, illegal, clr_vstart}), '0);
        end

        // R11: back-to-back issue, even then odd form
        drive(VECS[0]);
        @(negedge clk);
        check_result(VECS[0]);
        drive(VECS[1]);
        @(negedge clk);
        issue = 1'b0;
        check_result(VECS[1]);
        @(negedge clk);
        check("R11", GRP_W'({wr_en, illegal}), '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule